// File: doc/BRIEF.md
# Multi-Symbol Run-Length Encoder

This block compresses a stream of fixed-width symbols into (symbol, run length) pairs. Each input beat carries several symbol lanes plus a per-lane enable mask, and the whole beat is taken in one cycle. Inside, four registered stages are chained by valid/ready handshakes. The first stage folds equal neighbours inside a beat into pairs. The second packs those pairs into the low slots. The third joins a run that opens a beat with the run still pending from earlier beats, and splits runs that exceed the count range. The fourth cuts each group of pairs into output beats of a width the receiver chooses.

A stream ends with the last flag on an input beat. That flag flushes the pending run, and the output beat that carries the final pair of the stream is marked with a last flag of its own. The receiver may hold ready low at any time. Nothing is lost or repeated while it does, and the pipeline stalls back to the input.

The parameters are the symbol width, the lane count, the count width and the number of pair slots per output beat. The count range must be at least the lane count.

Top module: `rle_multi_enc`

## Requirements
- R1: The sequence of output pairs is the run-length code of the enabled input symbols in arrival order. Lane 0 (bits [SYM_W-1:0] of `in_sym`) comes first within a beat, and beats are taken in acceptance order. Each pair holds the symbol and its run length.
- R2: Lanes whose `in_lane_vld` bit is 0 are ignored. A run of one symbol continues across disabled lanes and across beats whose mask is all zero.
- R3: Equal symbols that span a beat boundary form one run. A stream of one repeated symbol yields only the pairs that the count limit forces, and no extra pairs appear at beat boundaries.
- R4: Counts never exceed MAX = 2^CNT_W-1. A longer run is sent as consecutive pairs of count MAX, followed by one pair holding the remainder (1..MAX). Counts are never 0.
- R5: An accepted beat with `in_last`=1 emits the pending run. The next beat starts a new stream, and no run merges across that boundary.
- R6: `out_last` is 1 on exactly one output beat per stream, the beat that carries the stream's final pair. A stream with no enabled symbol gives a single output beat with `out_pair_vld`=0 and `out_last`=1.
- R7: While `out_valid`=1 and `out_ready`=0, all outputs hold stable on the next cycle. No pair is dropped or duplicated under any ready pattern.
- R8: Output slot k sits at bits [k*SYM_W +: SYM_W] of `out_sym` and [k*CNT_W +: CNT_W] of `out_cnt`. Slot 0 is the earliest. Valid slots form a contiguous block from slot 0, so `out_pair_vld` is 2^n-1.
- R9: In the cycle after synchronous reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sym | input | LANES*SYM_W | Symbol lanes, lane 0 in the low bits |
| in_lane_vld | input | LANES | Per-lane enable |
| in_last | input | 1 | Beat ends the stream |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Receiver takes the output beat |
| out_sym | output | OUT_N*SYM_W | Pair symbols, slot 0 in the low bits |
| out_cnt | output | OUT_N*CNT_W | Pair run lengths |
| out_pair_vld | output | OUT_N | Valid slots in the beat |
| out_last | output | 1 | Beat carries the stream's final pair |

## Verification
The bench is built with four lanes, a three-bit count and two-slot output beats. It sends several kinds of stream:
- One symbol across full beats, which exposes saturation splitting and wrong merging at beat boundaries.
- One symbol under sparse masks, which shows whether disabled lanes break a run.
- All-distinct symbols, which fill every reduced slot and force multi-beat output groups.
- Two-symbol random streams with random masks, run with a free and with a randomly stalling receiver, which mix every case and expose loss or duplication under backpressure.
- Empty and back-to-back streams, which probe the flush and the placement of the last flag.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int DEF_SYM_W = 4;
  localparam int DEF_LANES = 4;
  localparam int DEF_CNT_W = 4;
  localparam int DEF_OUT_N = 2;

  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rle_reduce.sv
module rle_reduce #(
  parameter int SYM_W = 4,
  parameter int LANES = 4,
  parameter int RW    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            i_valid,
  output logic                            i_ready,
  input  logic [LANES-1:0][SYM_W-1:0]     i_sym,
  input  logic [LANES-1:0]                i_mask,
  input  logic                            i_last,
  output logic                            o_valid,
  input  logic                            o_ready,
  output logic [LANES-1:0][SYM_W-1:0]     o_sym,
  output logic [LANES-1:0][RW-1:0]        o_cnt,
  output logic [LANES-1:0]                o_mask,
  output logic                            o_last
);
  logic [LANES-1:0]              run_end;
  logic [LANES-1:0][RW-1:0]      run_len;
  logic                          seen;
  logic [SYM_W-1:0]              cur;
  logic [RW-1:0]                 len;
  int                            prev;

  // walk the lanes; a run's pair sits at the lane where the run ends
  always_comb begin
    run_end = '0;
    run_len = '0;
    seen    = 1'b0;
    cur     = '0;
    len     = '0;
    prev    = 0;
    for (int i = 0; i < LANES; i++) begin
      if (i_mask[i]) begin
        if (seen && i_sym[i] == cur) begin
          len           = len + 1'b1;
          run_end[prev] = 1'b0;
        end else begin
          len = RW'(1);
        end
        cur        = i_sym[i];
        run_end[i] = 1'b1;
        run_len[i] = len;
        prev       = i;
        seen       = 1'b1;
      end
    end
  end

  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_mask  <= '0;
      o_sym   <= '0;
      o_cnt   <= '0;
      o_last  <= 1'b0;
    end else if (i_ready) begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_sym  <= i_sym;
        o_cnt  <= run_len;
        o_mask <= run_end;
        o_last <= i_last;
      end
    end
  end

  int out_sum;
  always_comb begin
    out_sum = 0;
    for (int i = 0; i < LANES; i++)
      if (o_mask[i]) out_sum = out_sum + int'(o_cnt[i]);
  end

  // R2: the pairs of a beat account for exactly its enabled lanes
  a_r2_lane_total: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_ready) |=> (out_sum == $past($countones(i_mask))));
endmodule

// File: rtl/rle_align.sv
module rle_align #(
  parameter int SYM_W = 4,
  parameter int LANES = 4,
  parameter int RW    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            i_valid,
  output logic                            i_ready,
  input  logic [LANES-1:0][SYM_W-1:0]     i_sym,
  input  logic [LANES-1:0][RW-1:0]        i_cnt,
  input  logic [LANES-1:0]                i_mask,
  input  logic                            i_last,
  output logic                            o_valid,
  input  logic                            o_ready,
  output logic [LANES-1:0][SYM_W-1:0]     o_sym,
  output logic [LANES-1:0][RW-1:0]        o_cnt,
  output logic [RW-1:0]                   o_n,
  output logic                            o_last
);
  logic [LANES-1:0][SYM_W-1:0] pk_sym;
  logic [LANES-1:0][RW-1:0]    pk_cnt;
  int                          k;

  always_comb begin
    pk_sym = '0;
    pk_cnt = '0;
    k      = 0;
    for (int i = 0; i < LANES; i++) begin
      if (i_mask[i]) begin
        pk_sym[k] = i_sym[i];
        pk_cnt[k] = i_cnt[i];
        k         = k + 1;
      end
    end
  end

  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_sym   <= '0;
      o_cnt   <= '0;
      o_n     <= '0;
      o_last  <= 1'b0;
    end else if (i_ready) begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_sym  <= pk_sym;
        o_cnt  <= pk_cnt;
        o_n    <= RW'(k);
        o_last <= i_last;
      end
    end
  end

  // R1: packing keeps one slot per reduced pair
  a_r1_pack_count: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_ready) |=> (int'(o_n) == $past($countones(i_mask))));
endmodule

// File: rtl/rle_merge.sv
module rle_merge #(
  parameter int SYM_W = 4,
  parameter int LANES = 4,
  parameter int RW    = 3,
  parameter int CNT_W = 4,
  parameter int EN    = 5,
  parameter int EW    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            i_valid,
  output logic                            i_ready,
  input  logic [LANES-1:0][SYM_W-1:0]     i_sym,
  input  logic [LANES-1:0][RW-1:0]        i_cnt,
  input  logic [RW-1:0]                   i_n,
  input  logic                            i_last,
  output logic                            o_valid,
  input  logic                            o_ready,
  output logic [EN-1:0][SYM_W-1:0]        o_sym,
  output logic [EN-1:0][CNT_W-1:0]        o_cnt,
  output logic [EW-1:0]                   o_n,
  output logic                            o_last
);
  localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

  logic                     pv;
  logic [SYM_W-1:0]         ps;
  logic [CNT_W-1:0]         pc;

  logic                     cv;
  logic [SYM_W-1:0]         cs;
  logic [CNT_W:0]           cc, sum;
  logic [EN-1:0][SYM_W-1:0] es;
  logic [EN-1:0][CNT_W-1:0] ec;
  int                       ne;

  always_comb begin
    cv  = pv;
    cs  = ps;
    cc  = {1'b0, pc};
    sum = '0;
    ne  = 0;
    es  = '0;
    ec  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(i_n)) begin
        if (cv && i_sym[i] == cs) begin
          sum = cc + (CNT_W+1)'(i_cnt[i]);
          if (sum > MAXV) begin
            es[ne] = cs;
            ec[ne] = MAXV[CNT_W-1:0];
            ne     = ne + 1;
            cc     = sum - MAXV;
          end else begin
            cc = sum;
          end
        end else begin
          if (cv) begin
            es[ne] = cs;
            ec[ne] = cc[CNT_W-1:0];
            ne     = ne + 1;
          end
          cs = i_sym[i];
          cc = (CNT_W+1)'(i_cnt[i]);
          cv = 1'b1;
        end
      end
    end
    if (i_last && cv) begin
      es[ne] = cs;
      ec[ne] = cc[CNT_W-1:0];
      ne     = ne + 1;
    end
  end

  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv      <= 1'b0;
      ps      <= '0;
      pc      <= '0;
      o_valid <= 1'b0;
      o_sym   <= '0;
      o_cnt   <= '0;
      o_n     <= '0;
      o_last  <= 1'b0;
    end else if (i_ready) begin
      o_valid <= i_valid && (ne != 0 || i_last);
      if (i_valid) begin
        pv     <= cv && !i_last;
        ps     <= cs;
        pc     <= cc[CNT_W-1:0];
        o_sym  <= es;
        o_cnt  <= ec;
        o_n    <= EW'(ne);
        o_last <= i_last;
      end
    end
  end

  // R5: a last beat leaves no pending run behind
  a_r5_flush_clears: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_ready && i_last) |=> !pv);

  genvar g;
  generate
    for (g = 0; g < EN; g++) begin : g_cnt_chk
      // R4: every emitted pair has a non-zero count
      a_r4_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
        (o_valid && g < int'(o_n)) |-> (o_cnt[g] != '0));
    end
  endgenerate
endmodule

// File: rtl/rle_outw.sv
module rle_outw #(
  parameter int SYM_W = 4,
  parameter int CNT_W = 4,
  parameter int EN    = 5,
  parameter int EW    = 3,
  parameter int OUT_N = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            i_valid,
  output logic                            i_ready,
  input  logic [EN-1:0][SYM_W-1:0]        i_sym,
  input  logic [EN-1:0][CNT_W-1:0]        i_cnt,
  input  logic [EW-1:0]                   i_n,
  input  logic                            i_last,
  output logic                            o_valid,
  input  logic                            o_ready,
  output logic [OUT_N-1:0][SYM_W-1:0]     o_sym,
  output logic [OUT_N-1:0][CNT_W-1:0]     o_cnt,
  output logic [OUT_N-1:0]                o_vld,
  output logic                            o_last
);
  logic [EN-1:0][SYM_W-1:0] bs;
  logic [EN-1:0][CNT_W-1:0] bc;
  logic [EW-1:0]            bn;
  logic                     bl;
  logic                     gv;
  logic [EW-1:0]            idx;
  logic                     final_chunk;

  assign final_chunk = (int'(idx) + OUT_N) >= int'(bn);
  assign i_ready     = !gv || (o_ready && final_chunk);

  always_ff @(posedge clk) begin
    if (rst) begin
      gv  <= 1'b0;
      idx <= '0;
      bs  <= '0;
      bc  <= '0;
      bn  <= '0;
      bl  <= 1'b0;
    end else begin
      if (gv && o_ready) begin
        if (final_chunk) gv <= 1'b0;
        else             idx <= idx + EW'(OUT_N);
      end
      if (i_valid && i_ready) begin
        gv  <= 1'b1;
        idx <= '0;
        bs  <= i_sym;
        bc  <= i_cnt;
        bn  <= i_n;
        bl  <= i_last;
      end
    end
  end

  always_comb begin
    o_sym = '0;
    o_cnt = '0;
    o_vld = '0;
    for (int k = 0; k < OUT_N; k++) begin
      if (gv && (int'(idx) + k) < int'(bn) && (int'(idx) + k) < EN) begin
        o_vld[k] = 1'b1;
        o_sym[k] = bs[int'(idx) + k];
        o_cnt[k] = bc[int'(idx) + k];
      end
    end
  end

  assign o_valid = gv;
  assign o_last  = gv && bl && final_chunk;

  // R7: a stalled beat is held unchanged
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_sym) && $stable(o_cnt)
                               && $stable(o_vld) && $stable(o_last)));
  // R8: valid slots are contiguous from slot 0
  a_r8_low_slots: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> ((o_vld & (o_vld + 1'b1)) == '0));
endmodule

// File: rtl/rle_multi_enc.sv
module rle_multi_enc
  import rle_pkg::*;
#(
  parameter int SYM_W = DEF_SYM_W,
  parameter int LANES = DEF_LANES,
  parameter int CNT_W = DEF_CNT_W,
  parameter int OUT_N = DEF_OUT_N
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES*SYM_W-1:0]   in_sym,
  input  logic [LANES-1:0]         in_lane_vld,
  input  logic                     in_last,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [OUT_N*SYM_W-1:0]   out_sym,
  output logic [OUT_N*CNT_W-1:0]   out_cnt,
  output logic [OUT_N-1:0]         out_pair_vld,
  output logic                     out_last
);
  localparam int RW = width_for(LANES);
  localparam int EN = LANES + 1;
  localparam int EW = width_for(EN);

  logic [LANES-1:0][SYM_W-1:0] s0_sym;
  assign s0_sym = in_sym;

  logic                        r_v, r_rdy, r_last;
  logic [LANES-1:0][SYM_W-1:0] r_sym;
  logic [LANES-1:0][RW-1:0]    r_cnt;
  logic [LANES-1:0]            r_mask;

  logic                        a_v, a_rdy, a_last;
  logic [LANES-1:0][SYM_W-1:0] a_sym;
  logic [LANES-1:0][RW-1:0]    a_cnt;
  logic [RW-1:0]               a_n;

  logic                        m_v, m_rdy, m_last;
  logic [EN-1:0][SYM_W-1:0]    m_sym;
  logic [EN-1:0][CNT_W-1:0]    m_cnt;
  logic [EW-1:0]               m_n;

  logic [OUT_N-1:0][SYM_W-1:0] w_sym;
  logic [OUT_N-1:0][CNT_W-1:0] w_cnt;

  rle_reduce #(.SYM_W(SYM_W), .LANES(LANES), .RW(RW)) u_reduce (
    .clk(clk), .rst(rst),
    .i_valid(in_valid), .i_ready(in_ready), .i_sym(s0_sym),
    .i_mask(in_lane_vld), .i_last(in_last),
    .o_valid(r_v), .o_ready(r_rdy), .o_sym(r_sym), .o_cnt(r_cnt),
    .o_mask(r_mask), .o_last(r_last));

  rle_align #(.SYM_W(SYM_W), .LANES(LANES), .RW(RW)) u_align (
    .clk(clk), .rst(rst),
    .i_valid(r_v), .i_ready(r_rdy), .i_sym(r_sym), .i_cnt(r_cnt),
    .i_mask(r_mask), .i_last(r_last),
    .o_valid(a_v), .o_ready(a_rdy), .o_sym(a_sym), .o_cnt(a_cnt),
    .o_n(a_n), .o_last(a_last));

  rle_merge #(.SYM_W(SYM_W), .LANES(LANES), .RW(RW), .CNT_W(CNT_W),
              .EN(EN), .EW(EW)) u_merge (
    .clk(clk), .rst(rst),
    .i_valid(a_v), .i_ready(a_rdy), .i_sym(a_sym), .i_cnt(a_cnt),
    .i_n(a_n), .i_last(a_last),
    .o_valid(m_v), .o_ready(m_rdy), .o_sym(m_sym), .o_cnt(m_cnt),
    .o_n(m_n), .o_last(m_last));

  rle_outw #(.SYM_W(SYM_W), .CNT_W(CNT_W), .EN(EN), .EW(EW),
             .OUT_N(OUT_N)) u_outw (
    .clk(clk), .rst(rst),
    .i_valid(m_v), .i_ready(m_rdy), .i_sym(m_sym), .i_cnt(m_cnt),
    .i_n(m_n), .i_last(m_last),
    .o_valid(out_valid), .o_ready(out_ready), .o_sym(w_sym), .o_cnt(w_cnt),
    .o_vld(out_pair_vld), .o_last(out_last));

  assign out_sym = w_sym;
  assign out_cnt = w_cnt;

  // R9: pipeline empty and accepting right after reset
  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));
endmodule

// File: tb/test_rle_multi_enc.sv
module test_rle_multi_enc;
  localparam int SYM_W = 4;
  localparam int LANES = 4;
  localparam int CNT_W = 3;
  localparam int OUT_N = 2;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*SYM_W-1:0] in_sym = '0;
  logic [LANES-1:0] in_lane_vld = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [OUT_N*SYM_W-1:0] out_sym;
  logic [OUT_N*CNT_W-1:0] out_cnt;
  logic [OUT_N-1:0] out_pair_vld;
  logic out_last;

  always #10 clk = ~clk;

  rle_multi_enc #(.SYM_W(SYM_W), .LANES(LANES), .CNT_W(CNT_W), .OUT_N(OUT_N))
    i_rle_multi_enc (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_sym(in_sym), .in_lane_vld(in_lane_vld), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
      .out_cnt(out_cnt), .out_pair_vld(out_pair_vld), .out_last(out_last));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int exp_s [0:2047];
  int exp_c [0:2047];
  int n_exp = 0;
  int got_s [0:2047];
  int got_c [0:2047];
  int n_got = 0;
  int n_last = 0;
  int got_at_last = 0;
  int pack_bad = 0;
  int ready_mode = 0;

  bit m_have = 1'b0;
  int m_sym = 0;
  int m_cnt = 0;

  logic [31:0] rs = 32'h1234_5678;
  logic [31:0] rr = 32'h0bad_f00d;

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input int s, input int c);
    exp_s[n_exp] = s;
    exp_c[n_exp] = c;
    n_exp++;
  endtask

  task automatic model_sym(input int s);
    if (m_have && s == m_sym) begin
      if (m_cnt == MAXC) begin
        push_exp(m_sym, MAXC);
        m_cnt = 1;
      end else m_cnt++;
    end else begin
      if (m_have) push_exp(m_sym, m_cnt);
      m_sym = s; m_cnt = 1; m_have = 1'b1;
    end
  endtask

  task automatic model_flush();
    if (m_have) push_exp(m_sym, m_cnt);
    m_have = 1'b0;
  endtask

  // output monitor: set ready at the falling edge, record transfers after it
  initial begin
    forever begin
      @(negedge clk);
      if (ready_mode == 1) begin
        rr = step(rr);
        out_ready = rr[3] | rr[7];
      end else out_ready = 1'b1;
      #1;
      if (!rst && out_valid && out_ready) begin
        if ((out_pair_vld & (out_pair_vld + 1'b1)) != '0) pack_bad++;
        for (int k = 0; k < OUT_N; k++) begin
          if (out_pair_vld[k]) begin
            got_s[n_got] = int'(out_sym[k*SYM_W +: SYM_W]);
            got_c[n_got] = int'(out_cnt[k*CNT_W +: CNT_W]);
            n_got++;
          end
        end
        if (out_last) begin
          n_last++;
          got_at_last = n_got;
        end
      end
    end
  end

  task automatic send(input logic [LANES*SYM_W-1:0] s, input logic [LANES-1:0] m,
                      input logic l);
    logic r;
    @(negedge clk);
    in_valid = 1'b1; in_sym = s; in_lane_vld = m; in_last = l;
    forever begin
      #1 r = in_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (m[i]) model_sym(int'(s[i*SYM_W +: SYM_W]));
    if (l) model_flush();
  endtask

  // mode 0 one symbol full, 1 distinct, 2 two-symbol random, 3 sparse random,
  // 4 empty, 5 one symbol alternating masks
  task automatic run_stream(input int mode, input int nb, input int rmode, input string tag);
    logic [LANES*SYM_W-1:0] s;
    logic [LANES-1:0] m;
    n_exp = 0; n_got = 0; n_last = 0; got_at_last = 0; pack_bad = 0;
    ready_mode = rmode;
    for (int b = 0; b < nb; b++) begin
      rs = step(rs);
      for (int l = 0; l < LANES; l++) begin
        case (mode)
          0, 5:    s[l*SYM_W +: SYM_W] = 4'd5;
          1:       s[l*SYM_W +: SYM_W] = 4'((b * LANES + l) % 16);
          2:       s[l*SYM_W +: SYM_W] = rs[8+l] ? 4'd3 : 4'd9;
          default: s[l*SYM_W +: SYM_W] = rs[12+l] ? 4'd1 : 4'd2;
        endcase
      end
      case (mode)
        0, 1:    m = '1;
        2:       m = rs[3:0];
        3:       m = rs[3:0] & rs[7:4];
        4:       m = '0;
        default: m = (b % 2 == 0) ? 4'b0101 : 4'b1010;
      endcase
      send(s, m, b == nb - 1);
    end
    for (int t = 0; t < 4000 && n_last == 0; t++) @(negedge clk);
    repeat (12) @(negedge clk);
    check(n_got == n_exp, {tag, " R1 pair count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_s[i] == exp_s[i], {tag, " R1 symbol"}, got_s[i], exp_s[i]);
      check(got_c[i] == exp_c[i], {tag, " R4 count"}, got_c[i], exp_c[i]);
    end
    check(n_last == 1, {tag, " R6 last beats"}, n_last, 1);
    check(got_at_last == n_got, {tag, " R6 last on final pair"}, got_at_last, n_got);
    check(pack_bad == 0, {tag, " R8 slot packing"}, pack_bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
    run_stream(5, 3, 0, "R2 masked one run");
    check(n_got == 1 && got_c[0] == 6, "R2 single pair", got_c[0], 6);
    run_stream(0, 6, 0, "R3 one symbol saturating");
    check(n_got == 4, "R3 no extra pairs", n_got, 4);
    run_stream(1, 5, 1, "R8 distinct");
    run_stream(2, 40, 1, "R7 random stalled");
    run_stream(3, 30, 0, "R3 sparse");
    run_stream(4, 1, 0, "R6 empty");
    check(n_got == 0, "R6 empty has no pairs", n_got, 0);
    run_stream(2, 40, 0, "R1 random");
    run_stream(0, 2, 1, "R5 first");
    run_stream(0, 2, 0, "R5 second");
    check(n_got == 2 && got_c[0] == 7 && got_c[1] == 1, "R5 fresh stream", got_c[0], 7);
    run_stream(2, 60, 1, "R4 random stalled long");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule